// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block configures a target FPGA over a slave-serial link from a byte stream. A start pulse makes it pull the active-low program line low and wait for the target to acknowledge by pulling its init line low. It then releases program and waits for init to return high. Each of these waits has its own timeout, counted in 1 ms ticks that a cycle prescaler produces.

After the handshake the loader takes bytes over a valid/ready interface and discards them until it finds the bitstream preamble. The preamble depends on the mode. In plain mode it is a run of four 0xFF bytes. In alternate mode it is a 0xFF byte followed by a byte whose high nibble is 3. From the first preamble byte onward, every byte is shifted out MSB first on the configuration clock and data pins. Eight 0xFF padding bytes follow the last byte. The loader then waits for the target's done line.

The outcome is a sticky result: success, or one of three error codes. It stays valid until the next start.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, prog_n, cclk and cdata are 1, and busy, cfg_ok, cfg_err and in_ready are 0.
- R2: A start pulse while idle drives prog_n low in the next cycle, with cclk and cdata held high while prog_n is low. A start pulse while busy has no effect on the bits sent or on the result.
- R3: If init_sense is still high 3 ticks after prog_n falls, the block ends with cfg_err=1 and err_code=1. busy then stays high for exactly 3*TICK_CYCLES+1 cycles after the start edge.
- R4: If init_sense does not return high within INIT_HIGH_TICKS ticks after prog_n is released, the block ends with err_code=2. busy stays high for exactly INIT_HIGH_TICKS*TICK_CYCLES+1 cycles after the release.
- R5: In plain mode (alt_mode=0), bytes before the first run of four consecutive 0xFF bytes are dropped. The run itself and all later bytes are sent.
- R6: In alternate mode (alt_mode=1), bytes before the first 0xFF that is directly followed by a byte with bits [7:4]=0x3 are dropped. That 0xFF and all later bytes are sent.
- R7: Each byte goes out MSB first. Each bit is sent as four phases: clock low with data high, clock low with data equal to the bit, clock high with data equal to the bit, then clock high with data back at 1. Every phase lasts PHASE_CYCLES cycles, so the clock stays low for exactly 2*PHASE_CYCLES cycles. Data never falls while the clock is high.
- R8: After the byte flagged in_last, PAD_BYTES (8) bytes of 0xFF are sent. If the stream ends without a preamble, only the padding is sent.
- R9: After the padding, done_sense high within DONE_TICKS ticks ends the run with cfg_ok=1 and err_code=0. Otherwise the run ends with cfg_err=1 and err_code=3. cfg_ok and cfg_err are never both 1.
- R10: busy is high from the cycle after start until the result is posted. cfg_ok, cfg_err and err_code are cleared in the cycle after start and then hold their result until the next start.
- R11: in_ready is high only during preamble search and while the block waits for the next stream byte. No byte is taken before the init handshake completes. Gaps in in_valid lose no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin configuration |
| alt_mode | input | 1 | Preamble rule select, sampled at start (0 plain, 1 alternate) |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_last | input | 1 | Marks the final stream byte |
| in_ready | output | 1 | Loader accepts the byte this cycle |
| init_sense | input | 1 | Target init line level (asynchronous) |
| done_sense | input | 1 | Target done line level (asynchronous) |
| prog_n | output | 1 | Active-low program line |
| cclk | output | 1 | Configuration clock |
| cdata | output | 1 | Configuration serial data |
| busy | output | 1 | Configuration in progress |
| cfg_ok | output | 1 | Sticky success flag |
| cfg_err | output | 1 | Sticky failure flag |
| err_code | output | 2 | 0 none, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
The init-low and init-high timeouts have exact deadlines. The bench counts busy cycles from the start edge and from the prog_n release, and expects 3*TICK_CYCLES+1 and INIT_HIGH_TICKS*TICK_CYCLES+1 respectively, because the tick counter is cleared on the same edge as the state change. Every output is sampled on the falling system-clock edge, half a cycle after the registers update. The serial stream is captured at each cclk rise, and the clock-low width is counted in those falling-edge samples against 2*PHASE_CYCLES. The final status is read only after busy has dropped, then read again several cycles later to confirm that it holds.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG_LOW, ST_PROG_REL, ST_SCAN, ST_SEND, ST_PAD, ST_WAIT_DONE
  } cfgl_state_t;

  typedef enum logic [1:0] {
    RES_NONE      = 2'd0,
    RES_INIT_LOW  = 2'd1,
    RES_INIT_HIGH = 2'd2,
    RES_DONE      = 2'd3
  } cfgl_res_t;

  localparam int unsigned INIT_LOW_TICKS = 3;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int unsigned W = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= rst_val;
      else if (s == 0) pipe[s] <= d;
      else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfgl_tick_timer.sv
module cfgl_tick_timer #(
  parameter int unsigned TICK_CYCLES = 100000,
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [TW-1:0] ticks
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(TICK_CYCLES - 1);
  localparam logic [TW-1:0] TICK_MAX = '1;

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre   <= '0;
      ticks <= '0;
    end else if (pre == PRE_TOP) begin
      pre <= '0;
      if (ticks != TICK_MAX) ticks <= ticks + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/cfgl_preamble_det.sv
module cfgl_preamble_det (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       alt_mode,
  input  logic       strobe,
  input  logic [7:0] byte_in,
  output logic       hit,
  output logic [2:0] hit_ffs,
  output logic       hit_hold
);
  logic [1:0] ff_run;
  logic       is_ff;

  assign is_ff = (byte_in == 8'hFF);

  always_comb begin
    if (alt_mode) begin
      hit      = strobe && (ff_run != 2'd0) && (byte_in[7:4] == 4'h3);
      hit_ffs  = 3'd1;
      hit_hold = 1'b1;
    end else begin
      hit      = strobe && is_ff && (ff_run == 2'd3);
      hit_ffs  = 3'd4;
      hit_hold = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) ff_run <= '0;
    else if (strobe) begin
      if (!is_ff) ff_run <= '0;
      else if (ff_run != 2'd3) ff_run <= ff_run + 1'b1;
    end
  end
endmodule

// File: rtl/cfgl_serializer.sv
module cfgl_serializer #(
  parameter int unsigned PHASE_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] byte_in,
  output logic       ready,
  output logic       cclk,
  output logic       cdata
);
  localparam int unsigned PW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [PW-1:0] PH_TOP = PW'(PHASE_CYCLES - 1);

  logic          active;
  logic [7:0]    sh;
  logic [2:0]    bit_idx;
  logic [1:0]    phase;
  logic [PW-1:0] pcnt;

  assign ready = !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sh      <= '0;
      bit_idx <= '0;
      phase   <= '0;
      pcnt    <= '0;
      cclk    <= 1'b1;
      cdata   <= 1'b1;
    end else if (!active) begin
      if (load) begin
        active  <= 1'b1;
        sh      <= byte_in;
        bit_idx <= '0;
        phase   <= 2'd0;
        pcnt    <= '0;
        cclk    <= 1'b0;
        cdata   <= 1'b1;
      end
    end else if (pcnt != PH_TOP) begin
      pcnt <= pcnt + 1'b1;
    end else begin
      pcnt <= '0;
      case (phase)
        2'd0: begin
          phase <= 2'd1;
          cdata <= sh[7];
        end
        2'd1: begin
          phase <= 2'd2;
          cclk  <= 1'b1;
        end
        2'd2: begin
          phase <= 2'd3;
          cdata <= 1'b1;
        end
        default: begin
          if (bit_idx == 3'd7) begin
            active <= 1'b0;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            sh      <= {sh[6:0], 1'b0};
            phase   <= 2'd0;
            cclk    <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfgl_pkg::*;
#(
  parameter int unsigned TICK_CYCLES     = 100000,
  parameter int unsigned PHASE_CYCLES    = 2,
  parameter int unsigned INIT_HIGH_TICKS = 10,
  parameter int unsigned DONE_TICKS      = 100,
  parameter int unsigned PAD_BYTES       = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       alt_mode,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       init_sense,
  input  logic       done_sense,
  output logic       prog_n,
  output logic       cclk,
  output logic       cdata,
  output logic       busy,
  output logic       cfg_ok,
  output logic       cfg_err,
  output logic [1:0] err_code
);
  localparam int unsigned LIM_A  = (INIT_HIGH_TICKS > INIT_LOW_TICKS) ? INIT_HIGH_TICKS : INIT_LOW_TICKS;
  localparam int unsigned LIM_MX = (DONE_TICKS > LIM_A) ? DONE_TICKS : LIM_A;
  localparam int unsigned TW     = $clog2(LIM_MX + 1);
  localparam int unsigned CW     = $clog2(PAD_BYTES + 1);

  cfgl_state_t st, st_n;
  logic [TW-1:0] ticks;
  logic          tmr_clr;
  logic          init_s, done_s;
  logic          mode_q;
  logic [2:0]    ff_pend;
  logic [7:0]    hold;
  logic          hold_vld;
  logic          last_seen;
  logic [CW-1:0] pad_cnt;
  logic          ser_load, ser_ready;
  logic [7:0]    ser_byte;
  logic          take;
  logic          det_hit, det_hold;
  logic [2:0]    det_ffs;
  logic          kick;

  cfgl_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({init_sense, done_sense}), .rst_val(2'b10),
    .q({init_s, done_s})
  );

  cfgl_tick_timer #(.TICK_CYCLES(TICK_CYCLES), .TW(TW)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .ticks(ticks)
  );

  assign kick = (st == ST_IDLE) && start;

  cfgl_preamble_det u_det (
    .clk(clk), .rst(rst), .clr(kick), .alt_mode(mode_q),
    .strobe((st == ST_SCAN) && in_valid), .byte_in(in_data),
    .hit(det_hit), .hit_ffs(det_ffs), .hit_hold(det_hold)
  );

  cfgl_serializer #(.PHASE_CYCLES(PHASE_CYCLES)) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .byte_in(ser_byte),
    .ready(ser_ready), .cclk(cclk), .cdata(cdata)
  );

  always_comb begin
    st_n     = st;
    ser_load = 1'b0;
    ser_byte = 8'hFF;
    in_ready = 1'b0;
    take     = 1'b0;
    case (st)
      ST_IDLE: if (start) st_n = ST_PROG_LOW;
      ST_PROG_LOW: begin
        if (!init_s) st_n = ST_PROG_REL;
        else if (ticks == TW'(INIT_LOW_TICKS)) st_n = ST_IDLE;
      end
      ST_PROG_REL: begin
        if (init_s) st_n = ST_SCAN;
        else if (ticks == TW'(INIT_HIGH_TICKS)) st_n = ST_IDLE;
      end
      ST_SCAN: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (det_hit) st_n = ST_SEND;
          else if (in_last) st_n = ST_PAD;
        end
      end
      ST_SEND: begin
        if (ser_ready) begin
          if (ff_pend != 3'd0) ser_load = 1'b1;
          else if (hold_vld) begin
            ser_load = 1'b1;
            ser_byte = hold;
          end else if (last_seen) st_n = ST_PAD;
          else begin
            in_ready = 1'b1;
            if (in_valid) begin
              take     = 1'b1;
              ser_load = 1'b1;
              ser_byte = in_data;
            end
          end
        end
      end
      ST_PAD: begin
        if (ser_ready) begin
          if (pad_cnt == CW'(PAD_BYTES)) st_n = ST_WAIT_DONE;
          else ser_load = 1'b1;
        end
      end
      ST_WAIT_DONE: begin
        if (done_s || ticks == TW'(DONE_TICKS)) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign tmr_clr = (st_n != st);
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      prog_n    <= 1'b1;
      cfg_ok    <= 1'b0;
      cfg_err   <= 1'b0;
      err_code  <= RES_NONE;
      mode_q    <= 1'b0;
      ff_pend   <= '0;
      hold      <= '0;
      hold_vld  <= 1'b0;
      last_seen <= 1'b0;
      pad_cnt   <= '0;
    end else begin
      st     <= st_n;
      prog_n <= (st_n != ST_PROG_LOW);
      if (kick) begin
        cfg_ok    <= 1'b0;
        cfg_err   <= 1'b0;
        err_code  <= RES_NONE;
        mode_q    <= alt_mode;
        ff_pend   <= '0;
        hold_vld  <= 1'b0;
        last_seen <= 1'b0;
        pad_cnt   <= '0;
      end
      if (st == ST_SCAN && in_valid) begin
        if (det_hit) begin
          ff_pend  <= det_ffs;
          hold     <= in_data;
          hold_vld <= det_hold;
        end
        last_seen <= in_last;
      end
      if (st == ST_SEND && ser_load) begin
        if (ff_pend != 3'd0) ff_pend <= ff_pend - 1'b1;
        else if (hold_vld) hold_vld <= 1'b0;
      end
      if (take) last_seen <= in_last;
      if (st == ST_PAD && ser_load) pad_cnt <= pad_cnt + 1'b1;
      if (st_n == ST_IDLE && st != ST_IDLE) begin
        case (st)
          ST_PROG_LOW: begin
            cfg_err  <= 1'b1;
            err_code <= RES_INIT_LOW;
          end
          ST_PROG_REL: begin
            cfg_err  <= 1'b1;
            err_code <= RES_INIT_HIGH;
          end
          default: begin
            cfg_ok   <= done_s;
            cfg_err  <= !done_s;
            err_code <= done_s ? RES_NONE : RES_DONE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       in_ready,
  input logic       prog_n,
  input logic       cclk,
  input logic       cdata,
  input logic       busy,
  input logic       cfg_ok,
  input logic       cfg_err,
  input logic [1:0] err_code
);
  assert_lines_high_R2: assert property (@(posedge clk) disable iff (rst)
    !prog_n |-> (cclk && cdata));

  assert_start_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !prog_n));

  assert_data_no_fall_high_R7: assert property (@(posedge clk) disable iff (rst)
    (cclk && $past(cclk)) |-> !$fell(cdata));

  assert_clk_fall_data_high_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(cclk) |-> cdata);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(cfg_ok && cfg_err));

  assert_code_matches_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_err |-> err_code != 2'd0) and (cfg_ok |-> err_code == 2'd0));

  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(cfg_ok) && $stable(cfg_err) && $stable(err_code)));

  assert_ready_gated_R11: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (busy && prog_n));
endmodule

bind fpga_cfg_loader cfgl_checker chk_i (
  .clk(clk), .rst(rst), .start(start), .in_ready(in_ready), .prog_n(prog_n),
  .cclk(cclk), .cdata(cdata), .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err),
  .err_code(err_code)
);

// File: tb/fpga_cfg_loader_tb_top.sv
module fpga_cfg_loader_tb_top;
  localparam int TICK  = 10;
  localparam int PHASE = 2;
  localparam int IHT   = 4;
  localparam int DNT   = 5;
  localparam int PAD   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, alt_mode = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready;
  logic init_line = 1'b1, done_line = 1'b0;
  logic prog_n, cclk, cdata, busy, cfg_ok, cfg_err;
  logic [1:0] err_code;

  always #5 clk = ~clk;

  fpga_cfg_loader #(
    .TICK_CYCLES(TICK), .PHASE_CYCLES(PHASE), .INIT_HIGH_TICKS(IHT),
    .DONE_TICKS(DNT), .PAD_BYTES(PAD)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .alt_mode(alt_mode),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .init_sense(init_line), .done_sense(done_line), .prog_n(prog_n),
    .cclk(cclk), .cdata(cdata), .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err),
    .err_code(err_code)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] stream [16];
  bit exp_bits [256];
  bit cap_bits [256];
  int exp_n = 0, ncap = 0;
  bit en_lo = 1, en_hi = 1, en_done = 1;
  int lo_cnt = 0, hi_cnt = 0, low_w = 0;
  int viol_ph = 0, viol_len = 0, viol_prog = 0;
  int busy_cyc = 0, rel_cyc = 0;
  logic prev_cclk = 1'b1, prev_cdata = 1'b1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  endtask

  // target model and output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) busy_cyc++;
      if (busy && prog_n) rel_cyc++;
      if (!prog_n && !(cclk && cdata)) viol_prog++;
      if (cclk && !prev_cclk) begin
        if (ncap < 256) cap_bits[ncap] = cdata;
        ncap++;
        if (low_w != 2*PHASE) viol_len++;
      end
      if (!cclk && prev_cclk && !prev_cdata) viol_ph++;
      if (!cclk) low_w++;
      else low_w = 0;
      if (!prog_n) begin
        lo_cnt++;
        hi_cnt = 0;
        done_line = 1'b0;
        if (en_lo && lo_cnt >= 3) init_line = 1'b0;
      end else begin
        lo_cnt = 0;
        hi_cnt++;
        if (en_hi && !init_line && hi_cnt >= 5) init_line = 1'b1;
      end
      if (en_done && busy && exp_n > 0 && ncap == exp_n) done_line = 1'b1;
    end
    prev_cclk  = cclk;
    prev_cdata = cdata;
  end

  task automatic push(input logic [7:0] b, input logic l, output bit took);
    in_data = b; in_last = l; in_valid = 1'b1; took = 0;
    #1;
    while (!in_ready && busy) begin
      @(negedge clk); #1;
    end
    if (in_ready) begin
      took = 1;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input bit alt, input int n, input bit lo, input bit hi, input bit dn,
                          input int gap, input int restart_at, input int exp_code, input string req);
    int idx;
    int took_cnt;
    bit t;
    bit same;
    logic s_ok, s_err;
    logic [1:0] s_code;
    idx = n;
    for (int i = 0; i < n; i++) begin
      if (idx == n) begin
        if (!alt && i + 3 < n && stream[i] == 8'hFF && stream[i+1] == 8'hFF &&
            stream[i+2] == 8'hFF && stream[i+3] == 8'hFF) idx = i;
        if (alt && i + 1 < n && stream[i] == 8'hFF && stream[i+1][7:4] == 4'h3) idx = i;
      end
    end
    exp_n = 0;
    if (lo && hi) begin
      for (int i = idx; i < n; i++)
        for (int b = 7; b >= 0; b--) begin exp_bits[exp_n] = stream[i][b]; exp_n++; end
      for (int i = 0; i < PAD*8; i++) begin exp_bits[exp_n] = 1'b1; exp_n++; end
    end
    en_lo = lo; en_hi = hi; en_done = dn;
    init_line = 1'b1; done_line = 1'b0;
    ncap = 0; viol_ph = 0; viol_len = 0; viol_prog = 0; busy_cyc = 0; rel_cyc = 0;
    alt_mode = alt;
    pulse_start();
    chk(busy && !cfg_ok && !cfg_err && err_code == 0, "R10", {req, " cleared on start"},
        {busy, cfg_ok, cfg_err}, 4);
    chk(!prog_n, "R2", {req, " prog_n low after start"}, prog_n, 0);
    took_cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (i == restart_at) pulse_start();
      if (busy) begin
        push(stream[i], (i == n - 1), t);
        if (t) took_cnt++;
        repeat (gap) @(negedge clk);
      end
    end
    while (busy) @(negedge clk);
    chk(err_code == exp_code[1:0], req, "error code", err_code, exp_code);
    chk(cfg_ok == (exp_code == 0) && cfg_err == (exp_code != 0), "R9", {req, " ok/err flags"},
        {cfg_ok, cfg_err}, (exp_code == 0) ? 2 : 1);
    chk(ncap == exp_n, "R8", {req, " bit count"}, ncap, exp_n);
    same = (ncap == exp_n);
    for (int i = 0; i < exp_n && i < 256; i++) if (cap_bits[i] != exp_bits[i]) same = 0;
    chk(same, alt ? "R6" : "R5", {req, " bit sequence"}, same, 1);
    chk(viol_ph == 0 && viol_len == 0, "R7", {req, " phase order and clock-low width"},
        viol_ph + viol_len, 0);
    chk(viol_prog == 0, "R2", {req, " lines high during program"}, viol_prog, 0);
    if (exp_code == 1) chk(busy_cyc == 3*TICK + 1, "R3", "init-low deadline", busy_cyc, 3*TICK + 1);
    if (exp_code == 2) chk(rel_cyc == IHT*TICK + 1, "R4", "init-high deadline", rel_cyc, IHT*TICK + 1);
    if (exp_code == 1 || exp_code == 2) chk(took_cnt == 0, "R11", "no byte taken", took_cnt, 0);
    else chk(took_cnt == n, "R11", {req, " all bytes taken"}, took_cnt, n);
    s_ok = cfg_ok; s_err = cfg_err; s_code = err_code;
    repeat (8) @(negedge clk);
    chk(cfg_ok == s_ok && cfg_err == s_err && err_code == s_code && !busy, "R10",
        {req, " status held"}, err_code, s_code);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(prog_n && cclk && cdata, "R1", "lines high after reset", {prog_n, cclk, cdata}, 7);
    chk(!busy && !cfg_ok && !cfg_err, "R1", "flags low after reset", {busy, cfg_ok, cfg_err}, 0);
    chk(!in_ready, "R1", "in_ready low after reset", in_ready, 0);

    // R5 plain mode with header and partial runs
    stream[0] = 8'h12; stream[1] = 8'hFF; stream[2] = 8'hFF; stream[3] = 8'h00;
    stream[4] = 8'hFF; stream[5] = 8'hFF; stream[6] = 8'hFF; stream[7] = 8'hFF;
    stream[8] = 8'hA5; stream[9] = 8'h3C; stream[10] = 8'h00;
    run_case(0, 11, 1, 1, 1, 0, -1, 0, "R5");

    // R5 five 0xFF in a row after header byte
    stream[0] = 8'h55; stream[1] = 8'hFF; stream[2] = 8'hFF; stream[3] = 8'hFF;
    stream[4] = 8'hFF; stream[5] = 8'hFF; stream[6] = 8'h81;
    run_case(0, 7, 1, 1, 1, 0, -1, 0, "R5");

    // R6 alternate mode, two 0xFF before the 3x byte
    stream[0] = 8'h07; stream[1] = 8'hFF; stream[2] = 8'hFF; stream[3] = 8'h31; stream[4] = 8'h5A;
    run_case(1, 5, 1, 1, 1, 0, -1, 0, "R6");

    // R6 alternate mode, false start with 0x20, preamble byte is last
    stream[0] = 8'hFF; stream[1] = 8'h20; stream[2] = 8'hFF; stream[3] = 8'h3F;
    run_case(1, 4, 1, 1, 1, 0, -1, 0, "R6");

    // R8 no preamble at all: padding only
    stream[0] = 8'h11; stream[1] = 8'h22; stream[2] = 8'hFF;
    run_case(0, 3, 1, 1, 1, 0, -1, 0, "R8");

    // R11 flow control gaps, R2 start ignored while busy
    stream[0] = 8'hFF; stream[1] = 8'hFF; stream[2] = 8'hFF; stream[3] = 8'hFF;
    stream[4] = 8'h96; stream[5] = 8'h0F; stream[6] = 8'hE1;
    run_case(0, 7, 1, 1, 1, 3, 5, 0, "R11");

    // R3 init never goes low
    run_case(0, 7, 0, 1, 1, 0, -1, 1, "R3");
    // R4 init never returns high
    run_case(0, 7, 1, 0, 1, 0, -1, 2, "R4");
    // R9 done never rises
    run_case(0, 7, 1, 1, 0, 0, -1, 3, "R9");
    // R10 a good run after a failure clears the status
    run_case(1, 5, 1, 1, 1, 1, -1, 0, "R10");

    summary();
  end
endmodule